// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits in front of an instruction fetch unit shared by several hardware threads. It keeps one program counter for every thread. In each cycle it picks a single thread that is allowed to fetch and presents that thread's identifier and PC on a valid/ready fetch request port. Eligible threads take turns in rotating order. A thread that has started a long-latency operation is parked by a per-thread stall pulse. It stays out of the rotation until a resume pulse brings it back, and it uses up no turn while parked.

A critical-thread input can name one thread that wins the fetch slot whenever it is eligible. This protects single-thread performance under a multiprogrammed load. Redirect inputs overwrite the PC of any thread, for example after a branch resolves. An accepted fetch advances the granted thread's PC by the fetch block size. The parameter `PRIO_SUPPORT` selects whether the critical-thread path is built at all.

Top module: `fetch_thread_sel`

## Requirements
- R1: After reset no thread is suspended, the rotation pointer is at thread 0, and thread t holds PC `PC_RESET_BASE + t*PC_RESET_STRIDE` (truncated to `PC_W` bits). The first request therefore names thread 0.
- R2: With no critical thread active, the request names the first non-suspended thread at or after the rotation pointer, counting upward with wrap-around. When such a request is accepted, the pointer moves to the thread after the one granted.
- R3: A thread that is suspended is never named by a valid request. A stall pulse on `stall_i[t]` suspends thread t from the next cycle onward.
- R4: A pulse on `resume_i[t]` alone makes thread t eligible again from the next cycle. Stall and resume pulsed together for the same thread leave that thread suspended.
- R5: When every thread is suspended, `fetch_valid_o` is low and the rotation pointer does not move.
- R6: When `PRIO_SUPPORT` is 1, `prio_en_i` is high and thread `prio_tid_i` is not suspended, the request names `prio_tid_i`. A grant made this way leaves the rotation pointer unchanged.
- R7: When the named critical thread is suspended, the selection falls back to the rotation of R2.
- R8: The granted thread's PC increases by `FETCH_BYTES` (modulo 2^`PC_W`) only in a cycle where both `fetch_valid_o` and `fetch_ready_i` are high. While ready is low, the PC and the rotation pointer hold, so the same request is repeated.
- R9: `redir_valid_i` loads `redir_pc_i` into the PC of thread `redir_tid_i` on the next cycle. This overrides an advance of that thread in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | NUM_THREADS | Per-thread suspend pulse |
| resume_i | input | NUM_THREADS | Per-thread wake pulse |
| prio_en_i | input | 1 | Critical-thread priority enable |
| prio_tid_i | input | TID_W | Identifier of the critical thread |
| redir_valid_i | input | 1 | Redirect strobe |
| redir_tid_i | input | TID_W | Thread whose PC is redirected |
| redir_pc_i | input | PC_W | New PC for the redirected thread |
| fetch_ready_i | input | 1 | Fetch unit accepts the request |
| fetch_valid_o | output | 1 | A thread is selected this cycle |
| fetch_tid_o | output | TID_W | Selected thread |
| fetch_pc_o | output | PC_W | PC of the selected thread |

## Verification
The assertions take the redirect and critical-thread identifiers to name existing threads. They also take the control inputs to be settled before each clock edge. The bench only ever drives thread identifiers in the range 0 to 3 on a four-thread build. It changes every input on the falling edge, half a cycle away from the edges where the design samples. Stall, resume, critical-thread and redirect pulses are mixed freely, including the same-cycle collisions, because the block defines an outcome for every combination of them.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // Index of the slot after idx in a ring of n slots.
   function automatic int ring_next(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/fts_thread_ctx.sv
module fts_thread_ctx #(
   parameter int               PC_W     = 32,
   parameter int unsigned      STEP     = 16,
   parameter logic [PC_W-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic            resume_i,
   input  logic            redir_i,
   input  logic [PC_W-1:0] redir_pc_i,
   input  logic            adv_i,
   output logic            susp_o,
   output logic [PC_W-1:0] pc_o
);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   logic            susp_q;
   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         pc_q   <= RESET_PC;
      end else begin
         if (stall_i)       susp_q <= 1'b1;
         else if (resume_i) susp_q <= 1'b0;
         if (redir_i)       pc_q   <= redir_pc_i;
         else if (adv_i)    pc_q   <= pc_q + STEP_V;
      end
   end

   assign susp_o = susp_q;
   assign pc_o   = pc_q;

   p_stall_dominates_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> susp_o);
   p_resume_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_i && !stall_i) |=> !susp_o);
   p_redirect_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_i |=> (pc_o == $past(redir_pc_i)));
   p_advance_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !redir_i) |=> (pc_o == $past(pc_o) + STEP_V));
   p_pc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !redir_i) |=> $stable(pc_o));
endmodule

// File: rtl/fts_arbiter.sv
module fts_arbiter #(
   parameter int N            = 4,
   parameter bit PRIO_SUPPORT = 1'b1,
   localparam int TID_W       = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     elig_i,
   input  logic             prio_en_i,
   input  logic [TID_W-1:0] prio_tid_i,
   input  logic             accept_i,
   output logic             any_o,
   output logic [TID_W-1:0] gnt_tid_o
);
   import fts_pkg::*;

   logic [TID_W-1:0] ptr_q;
   logic [TID_W-1:0] rr_tid;
   logic             rr_found;
   logic             prio_hit;

   // Rotating search starting at the pointer.
   always_comb begin
      rr_tid   = ptr_q;
      rr_found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % N;
         if (!rr_found && elig_i[idx]) begin
            rr_found = 1'b1;
            rr_tid   = TID_W'(idx);
         end
      end
   end

   generate
      if (PRIO_SUPPORT) begin : g_prio
         assign prio_hit = prio_en_i && (int'(prio_tid_i) < N) && elig_i[prio_tid_i];
      end else begin : g_noprio
         assign prio_hit = 1'b0;
      end
   endgenerate

   assign any_o     = |elig_i;
   assign gnt_tid_o = prio_hit ? prio_tid_i : rr_tid;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (accept_i && any_o && !prio_hit)
         ptr_q <= TID_W'(ring_next(int'(gnt_tid_o), N));
   end

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !any_o |=> $stable(ptr_q));
   p_stalled_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_i |=> $stable(ptr_q));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
   parameter int          NUM_THREADS     = 4,
   parameter int          PC_W            = 32,
   parameter int unsigned FETCH_BYTES     = 16,
   parameter int unsigned PC_RESET_BASE   = 32'h0000_0000,
   parameter int unsigned PC_RESET_STRIDE = 32'h0000_1000,
   parameter bit          PRIO_SUPPORT    = 1'b1,
   localparam int         TID_W           = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] stall_i,
   input  logic [NUM_THREADS-1:0] resume_i,
   input  logic                   prio_en_i,
   input  logic [TID_W-1:0]       prio_tid_i,
   input  logic                   redir_valid_i,
   input  logic [TID_W-1:0]       redir_tid_i,
   input  logic [PC_W-1:0]        redir_pc_i,
   input  logic                   fetch_ready_i,
   output logic                   fetch_valid_o,
   output logic [TID_W-1:0]       fetch_tid_o,
   output logic [PC_W-1:0]        fetch_pc_o
);
   initial begin
      chk_threads: assert (NUM_THREADS >= 2 && NUM_THREADS <= 64)
         else $error("NUM_THREADS out of range");
      chk_width: assert (PC_W >= 2 && PC_W <= 64)
         else $error("PC_W out of range");
      chk_step: assert (FETCH_BYTES > 0)
         else $error("FETCH_BYTES must be nonzero");
   end

   logic [NUM_THREADS-1:0] susp_vec;
   logic [PC_W-1:0]        pc_vec [NUM_THREADS];
   logic                   accept;

   assign accept = fetch_valid_o && fetch_ready_i;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         localparam logic [PC_W-1:0] RST_PC =
            PC_W'(longint'(PC_RESET_BASE) + longint'(t) * longint'(PC_RESET_STRIDE));
         fts_thread_ctx #(
            .PC_W     (PC_W),
            .STEP     (FETCH_BYTES),
            .RESET_PC (RST_PC)
         ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .stall_i    (stall_i[t]),
            .resume_i   (resume_i[t]),
            .redir_i    (redir_valid_i && (int'(redir_tid_i) == t)),
            .redir_pc_i (redir_pc_i),
            .adv_i      (accept && (int'(fetch_tid_o) == t)),
            .susp_o     (susp_vec[t]),
            .pc_o       (pc_vec[t])
         );
      end
   endgenerate

   fts_arbiter #(
      .N            (NUM_THREADS),
      .PRIO_SUPPORT (PRIO_SUPPORT)
   ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .elig_i     (~susp_vec),
      .prio_en_i  (prio_en_i),
      .prio_tid_i (prio_tid_i),
      .accept_i   (accept),
      .any_o      (fetch_valid_o),
      .gnt_tid_o  (fetch_tid_o)
   );

   assign fetch_pc_o = pc_vec[fetch_tid_o];

   p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid_o |-> !susp_vec[fetch_tid_o]);
   p_prio_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (PRIO_SUPPORT && prio_en_i && !susp_vec[prio_tid_i]) |-> (fetch_tid_o == prio_tid_i));
   p_all_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&susp_vec) |-> !fetch_valid_o);
endmodule

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
   localparam int          N      = 4;
   localparam int          PW     = 16;
   localparam int unsigned FB     = 8;
   localparam int unsigned BASE   = 32'h1000;
   localparam int unsigned STRIDE = 32'h0400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  stall_i = '0, resume_i = '0;
   logic          prio_en_i = 1'b0;
   logic [1:0]    prio_tid_i = '0;
   logic          redir_valid_i = 1'b0;
   logic [1:0]    redir_tid_i = '0;
   logic [PW-1:0] redir_pc_i = '0;
   logic          fetch_ready_i = 1'b0;
   logic          fetch_valid_o;
   logic [1:0]    fetch_tid_o;
   logic [PW-1:0] fetch_pc_o;

   int checks = 0, fails = 0;

   // Reference state
   logic [N-1:0]  msusp;
   int            mptr;
   logic [PW-1:0] mpc [N];

   always #5 clk = ~clk;

   fetch_thread_sel #(
      .NUM_THREADS(N), .PC_W(PW), .FETCH_BYTES(FB),
      .PC_RESET_BASE(BASE), .PC_RESET_STRIDE(STRIDE), .PRIO_SUPPORT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .resume_i(resume_i),
      .prio_en_i(prio_en_i), .prio_tid_i(prio_tid_i),
      .redir_valid_i(redir_valid_i), .redir_tid_i(redir_tid_i), .redir_pc_i(redir_pc_i),
      .fetch_ready_i(fetch_ready_i), .fetch_valid_o(fetch_valid_o),
      .fetch_tid_o(fetch_tid_o), .fetch_pc_o(fetch_pc_o)
   );

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic model_reset();
      msusp = '0;
      mptr  = 0;
      for (int t = 0; t < N; t++) mpc[t] = PW'(BASE + t * STRIDE);
   endtask

   task automatic step(input logic [N-1:0] st, input logic [N-1:0] rs,
                       input logic pe, input logic [1:0] pt,
                       input logic rv, input logic [1:0] rt, input logic [PW-1:0] rp,
                       input logic rdy, input string tag);
      bit ev, phit, found;
      int eg;
      @(negedge clk);
      stall_i = st; resume_i = rs; prio_en_i = pe; prio_tid_i = pt;
      redir_valid_i = rv; redir_tid_i = rt; redir_pc_i = rp; fetch_ready_i = rdy;
      #1;
      ev   = (msusp != '1);
      phit = pe && !msusp[pt];
      eg   = mptr;
      found = 1'b0;
      if (phit) eg = int'(pt);
      else
         for (int k = 0; k < N; k++)
            if (!found && !msusp[(mptr + k) % N]) begin found = 1'b1; eg = (mptr + k) % N; end
      chk(tag, "valid", fetch_valid_o, ev);
      if (ev) begin
         chk(tag, "tid", fetch_tid_o, eg);
         chk(tag, "pc", fetch_pc_o, mpc[eg]);
      end
      // next reference state
      for (int t = 0; t < N; t++) begin
         if (rv && int'(rt) == t) mpc[t] = rp;
         else if (ev && rdy && eg == t) mpc[t] = mpc[t] + PW'(FB);
         if (st[t]) msusp[t] = 1'b1;
         else if (rs[t]) msusp[t] = 1'b0;
      end
      if (ev && rdy && !phit) mptr = (eg + 1) % N;
   endtask

   task automatic go(input logic rdy, input string tag);
      step('0, '0, 1'b0, 2'd0, 1'b0, 2'd0, '0, rdy, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset PCs and first thread, one request per thread
      for (int i = 0; i < N; i++) go(1'b1, "R1");
      // R2: rotation continues, PCs stepped
      for (int i = 0; i < 6; i++) go(1'b1, "R2");
      // R8: ready low holds thread, PC and pointer
      for (int i = 0; i < 3; i++) go(1'b0, "R8");
      go(1'b1, "R8");
      // R3: suspend thread 1 and 3, they are skipped
      step(4'b1010, '0, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R3");
      for (int i = 0; i < 5; i++) go(1'b1, "R3");
      // R4: stall and resume together leaves thread 1 parked
      step(4'b0010, 4'b0010, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R4");
      for (int i = 0; i < 3; i++) go(1'b1, "R4");
      step('0, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R4");
      for (int i = 0; i < 4; i++) go(1'b1, "R4");
      // R5: everything parked, no request, pointer kept
      step(4'b1111, '0, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R5");
      for (int i = 0; i < 3; i++) go(1'b1, "R5");
      step('0, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R5");
      go(1'b1, "R5");
      step('0, 4'b1011, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R5");
      for (int i = 0; i < 4; i++) go(1'b1, "R5");
      // R6: critical thread 2 wins repeatedly, pointer left alone
      for (int i = 0; i < 4; i++)
         step('0, '0, 1'b1, 2'd2, 1'b0, 2'd0, '0, 1'b1, "R6");
      go(1'b1, "R6");
      // R7: critical thread parked, rotation takes over
      step(4'b0100, '0, 1'b1, 2'd2, 1'b0, 2'd0, '0, 1'b1, "R7");
      for (int i = 0; i < 4; i++)
         step('0, '0, 1'b1, 2'd2, 1'b0, 2'd0, '0, 1'b1, "R7");
      step('0, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, '0, 1'b1, "R7");
      // R9: redirect of the granted thread beats its advance
      step('0, '0, 1'b1, 2'd3, 1'b1, 2'd3, 16'hBEE0, 1'b1, "R9");
      step('0, '0, 1'b1, 2'd3, 1'b0, 2'd0, '0, 1'b1, "R9");
      step('0, '0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0040, 1'b0, "R9");
      for (int i = 0; i < N; i++) go(1'b1, "R9");
      // Sweep of mixed stimulus against the reference
      for (int i = 0; i < 4000; i++) begin
         logic [N-1:0] st, rs;
         st = '0; rs = '0;
         for (int t = 0; t < N; t++) begin
            st[t] = ($urandom_range(0, 9) == 0);
            rs[t] = ($urandom_range(0, 3) == 0);
         end
         step(st, rs, ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)),
              ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)), PW'($urandom),
              ($urandom_range(0, 3) != 0), "R2");
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule